// File: doc/BRIEF.md
# Bank Pin Interrupt Detector

This block watches one bank of already-synchronized input pins and turns selected pin activity into a single interrupt request. Each pin has its own detection setting built from three independent configuration bits: a kind bit (edge or level), a sense bit (which level or which edge), and a dual-edge bit that makes an edge-configured pin react to both transitions. Detected events are latched into a sticky pending register, which software clears by writing ones.

A mask register gates only the delivery of pending events to the interrupt line, never their detection. An event that arrives while its pin is masked stays pending and raises the interrupt as soon as the pin is unmasked. Software changes the mask through two write-one strobes: one that unmasks and one that masks. The current mask can be read but not written directly.

The register bus is a simple single-cycle write port plus a combinational read port addressed by the same address bus.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset, every mask bit reads 1 (masked), the pending register reads 0, the kind, sense and dual-edge registers read 0, and `irq` is low.
- R2: A write to the unmask strobe (offset 0x210) clears each mask bit whose data bit is 1; a write to the mask strobe (offset 0x214) sets each mask bit whose data bit is 1; data bits of 0 leave the mask unchanged; writing 0xFFFFFFFF to 0x214 masks all pins; a write to the mask view (offset 0x20C) has no effect. The mask view at 0x20C reads 1 for a masked pin, and both strobes read 0.
- R3: With the kind bit at 1 (edge), a sense bit of 1 makes only a 0-to-1 change of the pin latch a pending bit, and a sense bit of 0 makes only a 1-to-0 change latch it. A change is seen by comparing the pin with its level on the previous clock.
- R4: With the kind bit at 1 and the dual-edge bit at 1, both transitions latch a pending bit whatever the sense bit; with the kind bit at 0 the dual-edge bit changes nothing.
- R5: With the kind bit at 0 (level), the pending bit is latched on every cycle the pin equals the sense bit (1 = active high, 0 = active low), so clearing it while the level is still active leaves it set.
- R6: Pending bits (offset 0x218) are sticky; writing 1 to a bit clears it and writing 0 leaves it as it was.
- R7: Detection and latching continue while a pin is masked; a pending bit latched under mask asserts `irq` once that pin is unmasked.
- R8: `irq` is the OR of all pending bits whose mask bit is 0; with every pin masked it is low.
- R9: When a clearing write and a new event hit the same pending bit on the same clock, the bit stays set.
- R10: The kind (0x21C), sense (0x220) and dual-edge (0x224) registers read back the last value written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_lvl | input | NUM_PINS | Synchronized pin levels |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 12 | Register offset for reads and writes |
| bus_wdata | input | NUM_PINS | Write data |
| bus_rdata | output | NUM_PINS | Read data for `bus_addr`, combinational |
| irq | output | 1 | Aggregated interrupt request |

## Verification
A pin change driven between edges is latched into the pending register at the very next rising edge, and a bus write takes effect at the edge on which `bus_wr` is high; reads and `irq` are combinational from registers, so each result is due one edge after its stimulus. The bench drives every input on the falling edge, lets exactly one rising edge pass, and samples on the following falling edge. Same-edge collisions (a clearing write together with a pin change) are set up by driving both on one falling edge, so the single next rising edge decides the outcome.

// File: rtl/pin_irq_pkg.sv
`timescale 1ns/1ps
// Package: pin_irq_pkg
// Shared register offsets and the register-select type for the pin
// interrupt detector. Assumes a 12-bit byte offset bus.
package pin_irq_pkg;

    localparam int ADDR_W = 12;

    // Register offsets, fixed because system software decodes them.
    localparam logic [ADDR_W-1:0] OFS_MASK_VIEW = 12'h20C;
    localparam logic [ADDR_W-1:0] OFS_UNMASK    = 12'h210;
    localparam logic [ADDR_W-1:0] OFS_MASK_SET  = 12'h214;
    localparam logic [ADDR_W-1:0] OFS_PENDING   = 12'h218;
    localparam logic [ADDR_W-1:0] OFS_KIND      = 12'h21C;
    localparam logic [ADDR_W-1:0] OFS_SENSE     = 12'h220;
    localparam logic [ADDR_W-1:0] OFS_DUAL      = 12'h224;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MASK_VIEW,
        SEL_UNMASK,
        SEL_MASK_SET,
        SEL_PENDING,
        SEL_KIND,
        SEL_SENSE,
        SEL_DUAL
    } reg_sel_e;

    // Map a bus offset onto the register it addresses.
    function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] ofs);
        case (ofs)
            OFS_MASK_VIEW: decode_offset = SEL_MASK_VIEW;
            OFS_UNMASK:    decode_offset = SEL_UNMASK;
            OFS_MASK_SET:  decode_offset = SEL_MASK_SET;
            OFS_PENDING:   decode_offset = SEL_PENDING;
            OFS_KIND:      decode_offset = SEL_KIND;
            OFS_SENSE:     decode_offset = SEL_SENSE;
            OFS_DUAL:      decode_offset = SEL_DUAL;
            default:       decode_offset = SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/pin_irq_regs.sv
`timescale 1ns/1ps
// Module: pin_irq_regs
// Holds the per-pin configuration (kind, sense, dual-edge) and the mask,
// turns bus writes into mask updates and a pending-clear vector, and
// drives the combinational read mux. Assumes one write per bus_wr pulse.
module pin_irq_regs
    import pin_irq_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [NUM_PINS-1:0] bus_wdata,
    input  logic [NUM_PINS-1:0] pending_q,
    output logic [NUM_PINS-1:0] kind_q,
    output logic [NUM_PINS-1:0] sense_q,
    output logic [NUM_PINS-1:0] dual_q,
    output logic [NUM_PINS-1:0] mask_q,
    output logic [NUM_PINS-1:0] clear_vec,
    output logic [NUM_PINS-1:0] bus_rdata
);

    localparam logic [NUM_PINS-1:0] ALL_ONES = {NUM_PINS{1'b1}};

    reg_sel_e sel;

    // Decode the current bus offset once for both write and read paths.
    always_comb sel = decode_offset(bus_addr);

    // Configuration registers: plain read/write storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= '0;
            sense_q <= '0;
            dual_q  <= '0;
        end else if (bus_wr) begin
            if (sel == SEL_KIND)  kind_q  <= bus_wdata;
            if (sel == SEL_SENSE) sense_q <= bus_wdata;
            if (sel == SEL_DUAL)  dual_q  <= bus_wdata;
        end
    end

    // Mask register: reset masked, changed only through the two strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= ALL_ONES;
        end else if (bus_wr && sel == SEL_UNMASK) begin
            mask_q <= mask_q & ~bus_wdata;
        end else if (bus_wr && sel == SEL_MASK_SET) begin
            mask_q <= mask_q | bus_wdata;
        end
    end

    // Pending-clear vector: the ones written to the pending offset.
    always_comb clear_vec = (bus_wr && sel == SEL_PENDING) ? bus_wdata : '0;

    // Read mux; write-only strobes and unknown offsets return zero.
    always_comb begin
        case (sel)
            SEL_MASK_VIEW: bus_rdata = mask_q;
            SEL_PENDING:   bus_rdata = pending_q;
            SEL_KIND:      bus_rdata = kind_q;
            SEL_SENSE:     bus_rdata = sense_q;
            SEL_DUAL:      bus_rdata = dual_q;
            default:       bus_rdata = '0;
        endcase
    end

    // R2: ones written to the unmask strobe are unmasked on the next cycle.
    p_unmask_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_UNMASK) |=> ((mask_q & $past(bus_wdata)) == '0));

    // R2: ones written to the mask strobe are masked on the next cycle.
    p_mask_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_MASK_SET) |=> ((~mask_q & $past(bus_wdata)) == '0));

    // R2: the mask view offset is read-only.
    p_mask_view_ro_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_MASK_VIEW) |=> $stable(mask_q));

endmodule

// File: rtl/pin_irq_detect.sv
`timescale 1ns/1ps
// Module: pin_irq_detect
// Per-pin event detector. Each pin compares its level with the level
// seen on the previous clock for edges, or with its sense bit for levels.
// Assumes pin_lvl is already synchronous to clk.
module pin_irq_detect #(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_lvl,
    input  logic [NUM_PINS-1:0] kind_q,
    input  logic [NUM_PINS-1:0] sense_q,
    input  logic [NUM_PINS-1:0] dual_q,
    output logic [NUM_PINS-1:0] event_vec
);

    logic [NUM_PINS-1:0] prev_q;

    // Previous-level history; loaded during reset so no edge appears at exit.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= pin_lvl;
        else        prev_q <= pin_lvl;
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic rise, fall, edge_hit, level_hit;

        // Decode one pin's event from its three configuration bits.
        always_comb begin
            rise      = pin_lvl[p] & ~prev_q[p];
            fall      = ~pin_lvl[p] & prev_q[p];
            edge_hit  = dual_q[p] ? (rise | fall) : (sense_q[p] ? rise : fall);
            level_hit = sense_q[p] ? pin_lvl[p] : ~pin_lvl[p];
            event_vec[p] = kind_q[p] ? edge_hit : level_hit;
        end
    end

    // R3: an edge-configured pin reports an event only when its level changed.
    p_edge_needs_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((event_vec & kind_q & ~(pin_lvl ^ prev_q)) == '0));

    // R5: a level-configured pin reports an event only while at its sense level.
    p_level_matches_sense_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((event_vec & ~kind_q & (pin_lvl ^ sense_q)) == '0));

endmodule

// File: rtl/pin_irq_pending.sv
`timescale 1ns/1ps
// Module: pin_irq_pending
// Sticky pending register with write-one-to-clear and event priority,
// plus the masked OR that forms the interrupt request. Masking never
// stops latching; it only gates the output.
module pin_irq_pending #(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] event_vec,
    input  logic [NUM_PINS-1:0] clear_vec,
    input  logic [NUM_PINS-1:0] mask_q,
    output logic [NUM_PINS-1:0] pending_q,
    output logic                irq
);

    // Latch events; a same-cycle event overrides a clear of that bit.
    always_ff @(posedge clk) begin
        if (!rst_n) pending_q <= '0;
        else        pending_q <= (pending_q & ~clear_vec) | event_vec;
    end

    // Deliver any pending bit whose pin is unmasked.
    always_comb irq = |(pending_q & ~mask_q);

    // R6: a pending bit only drops when a one was written to it.
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(pending_q) & ~$past(clear_vec)) & ~pending_q) == '0));

    // R9: every detected event is pending on the next cycle, clear or not.
    p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (event_vec != '0) |=> ((pending_q & $past(event_vec)) == $past(event_vec)));

    // R8: with every pin masked the request stays low.
    p_all_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_q) |-> !irq);

endmodule

// File: rtl/pin_irq_ctrl.sv
`timescale 1ns/1ps
// Module: pin_irq_ctrl
// Top of the bank pin interrupt detector: register file, per-pin event
// detection and sticky pending logic. Assumes synchronized pin inputs
// and a bus data width equal to the number of pins.
module pin_irq_ctrl
    import pin_irq_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_lvl,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [NUM_PINS-1:0] bus_wdata,
    output logic [NUM_PINS-1:0] bus_rdata,
    output logic                irq
);

    logic [NUM_PINS-1:0] kind_q, sense_q, dual_q, mask_q;
    logic [NUM_PINS-1:0] clear_vec, event_vec, pending_q;

    pin_irq_regs #(.NUM_PINS(NUM_PINS)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .pending_q (pending_q),
        .kind_q    (kind_q),
        .sense_q   (sense_q),
        .dual_q    (dual_q),
        .mask_q    (mask_q),
        .clear_vec (clear_vec),
        .bus_rdata (bus_rdata)
    );

    pin_irq_detect #(.NUM_PINS(NUM_PINS)) i_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_lvl   (pin_lvl),
        .kind_q    (kind_q),
        .sense_q   (sense_q),
        .dual_q    (dual_q),
        .event_vec (event_vec)
    );

    pin_irq_pending #(.NUM_PINS(NUM_PINS)) i_pending (
        .clk       (clk),
        .rst_n     (rst_n),
        .event_vec (event_vec),
        .clear_vec (clear_vec),
        .mask_q    (mask_q),
        .pending_q (pending_q),
        .irq       (irq)
    );

    // R7: a pending bit on a pin that just became unmasked raises the request.
    p_unmask_delivers_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((pending_q & ~mask_q) != '0) |-> irq);

endmodule

// File: tb/test_pin_irq_ctrl.sv
`timescale 1ns/1ps
// Directed bench for pin_irq_ctrl: one task per scenario, each checking
// its own results. Inputs change on falling edges, results are sampled
// on the falling edge after the rising edge that must produce them.
module test_pin_irq_ctrl;

    localparam int NP = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin_lvl = '1;
    logic          bus_wr = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [NP-1:0] bus_wdata = '0;
    logic [NP-1:0] bus_rdata;
    logic          irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pin_irq_ctrl #(.NUM_PINS(NP)) i_pin_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_check(input string req, input logic [11:0] a, input logic [31:0] exp);
        bus_addr = a;
        #0.5;
        check(req, bus_rdata, exp);
    endtask

    task automatic set_pin(input int p, input logic v);
        pin_lvl[p] = v;
        tick();
    endtask

    task automatic t_reset();
        rd_check("R1 mask", 12'h20C, 32'hFFFF_FFFF);
        rd_check("R1 pending", 12'h218, 32'h0);
        rd_check("R1 kind", 12'h21C, 32'h0);
        rd_check("R1 sense", 12'h220, 32'h0);
        rd_check("R1 dual", 12'h224, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_config();
        wr(12'h21C, 32'h0000_0007);
        wr(12'h220, 32'h0000_0001);
        wr(12'h224, 32'h0000_000C);
        rd_check("R10 kind", 12'h21C, 32'h0000_0007);
        rd_check("R10 sense", 12'h220, 32'h0000_0001);
        rd_check("R10 dual", 12'h224, 32'h0000_000C);
        rd_check("R2 unmask strobe reads 0", 12'h210, 32'h0);
        rd_check("R2 mask strobe reads 0", 12'h214, 32'h0);
        rd_check("R10 no spurious pending", 12'h218, 32'h0);
    endtask

    task automatic t_edges();
        set_pin(0, 1'b0);
        rd_check("R3 rising pin ignores fall", 12'h218, 32'h0);
        set_pin(0, 1'b1);
        rd_check("R3 rising latched", 12'h218, 32'h1);
        check("R7 masked no irq", {31'b0, irq}, 32'h0);
        wr(12'h210, 32'h1);
        check("R7 unmask delivers", {31'b0, irq}, 32'h1);
        wr(12'h218, 32'h1);
        rd_check("R6 w1c clears", 12'h218, 32'h0);
        check("R8 irq drops", {31'b0, irq}, 32'h0);
        set_pin(1, 1'b0);
        rd_check("R3 falling latched", 12'h218, 32'h2);
        check("R7 still masked", {31'b0, irq}, 32'h0);
        wr(12'h210, 32'h2);
        check("R7 late unmask", {31'b0, irq}, 32'h1);
        set_pin(1, 1'b1);
        wr(12'h218, 32'h2);
        rd_check("R3 falling pin ignores rise", 12'h218, 32'h0);
    endtask

    task automatic t_dual();
        set_pin(2, 1'b0);
        rd_check("R4 dual fall", 12'h218, 32'h4);
        wr(12'h218, 32'h0);
        rd_check("R6 zero write keeps", 12'h218, 32'h4);
        wr(12'h218, 32'h4);
        rd_check("R6 cleared", 12'h218, 32'h0);
        set_pin(2, 1'b1);
        rd_check("R4 dual rise", 12'h218, 32'h4);
        wr(12'h218, 32'h4);
    endtask

    task automatic t_level();
        set_pin(3, 1'b0);
        rd_check("R5 active-low latched", 12'h218, 32'h8);
        wr(12'h218, 32'h8);
        rd_check("R5 re-set while active", 12'h218, 32'h8);
        // release and clear on the same edge: dual-edge bit must not act in level mode
        pin_lvl[3] = 1'b1; bus_wr = 1'b1; bus_addr = 12'h218; bus_wdata = 32'h8;
        tick();
        bus_wr = 1'b0; bus_wdata = '0;
        rd_check("R4 dual ignored in level", 12'h218, 32'h0);
    endtask

    task automatic t_collide();
        set_pin(0, 1'b0);
        set_pin(0, 1'b1);
        set_pin(0, 1'b0);
        rd_check("R9 setup", 12'h218, 32'h1);
        pin_lvl[0] = 1'b1; bus_wr = 1'b1; bus_addr = 12'h218; bus_wdata = 32'h1;
        tick();
        bus_wr = 1'b0; bus_wdata = '0;
        rd_check("R9 event beats clear", 12'h218, 32'h1);
        wr(12'h218, 32'h1);
        rd_check("R9 later clear", 12'h218, 32'h0);
    endtask

    task automatic t_mask();
        rd_check("R2 after unmask", 12'h20C, 32'hFFFF_FFFC);
        wr(12'h210, 32'h0);
        rd_check("R2 zero unmask no effect", 12'h20C, 32'hFFFF_FFFC);
        wr(12'h20C, 32'h0);
        rd_check("R2 view is read-only", 12'h20C, 32'hFFFF_FFFC);
        wr(12'h214, 32'h1);
        rd_check("R2 mask one pin", 12'h20C, 32'hFFFF_FFFD);
        wr(12'h214, 32'hFFFF_FFFF);
        rd_check("R2 mask all", 12'h20C, 32'hFFFF_FFFF);
        set_pin(1, 1'b0);
        rd_check("R7 detects while masked", 12'h218, 32'h2);
        check("R8 all masked quiet", {31'b0, irq}, 32'h0);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_config();
        t_edges();
        t_dual();
        t_level();
        t_collide();
        t_mask();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule